// File: doc/BRIEF.md
# SPI EEPROM Page-Write Controller

This block is the device-side logic of a small serial EEPROM that carries out the write-to-array instruction. The host lowers chip select and sends an opcode byte, then an address byte, then one or more data bytes, most significant bit first. Each bit is taken on a rising serial clock edge. The data bytes are gathered in a page buffer.

When chip select rises on a byte boundary, a timed busy period starts. At the end of that period the buffered bytes are copied into the internal array. If the host raises chip select anywhere else, or if a protection or busy rule applies, the instruction is rejected and the array stays as it was.

All SPI pins are sampled by the system clock. The write-enable latch and the two block-protect bits are loaded through a preset port. A plain read port shows the array contents to the neighbouring read logic.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `wel`, `wip`, `bp` and `spi_miso_oe` are all 0, and every array byte reads 0.
- R2: A write frame has three parts, sent MSB first and sampled on `spi_sclk` rising edges while `spi_cs_n` is low. First comes the opcode `0000_a_010`, where `a` (opcode bit 3) is address bit 8. Then comes an address byte giving address bits 7..0. Then come the data bytes.
- R3: A write commits only if `spi_cs_n` rises after a whole number of data bytes (at least one). A rise in the middle of a byte, or right after the address byte, leaves the array unchanged and no busy period follows.
- R4: Consecutive data bytes of one frame go to consecutive addresses.
- R5: The address offset inside a page (PAGE bytes, 16 by default) wraps from the last slot of the page back to its first slot. The page number never changes within a frame.
- R6: `wip` rises in the cycle after the commit. It stays high for exactly TWC system clock cycles. The array keeps its old contents while `wip` is high and shows the new bytes once `wip` falls.
- R7: A write frame sent while `wel` is 0 changes nothing.
- R8: A write frame sent while `wip` is 1 changes nothing.
- R9: A write frame sent while `wp_n` is low changes nothing.
- R10: A write is rejected if its page lies in the protected region. The `bp` encoding is: 00 none, 01 the top quarter (address bits 8..7 = 11), 10 the top half (address bit 8 = 1), 11 the whole array.
- R11: `spi_miso_oe` stays 0 for every frame.
- R12: `wel` clears when a busy period ends, and when a frame that carried the write opcode ends without a commit. A frame with any other opcode leaves `wel` unchanged.
- R13: A one-cycle `preset_valid` pulse loads `wel` and `bp` from `preset_wel` and `preset_bp`. No other event changes `bp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, sampled by clk |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data into the device |
| spi_miso | output | 1 | Serial data out (never driven) |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| wp_n | input | 1 | Write protect, active low |
| preset_valid | input | 1 | Load strobe for the latch and protect bits |
| preset_wel | input | 1 | Value loaded into wel |
| preset_bp | input | 2 | Value loaded into bp |
| wel | output | 1 | Write-enable latch |
| wip | output | 1 | Write cycle in progress |
| bp | output | 2 | Block-protect bits |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at rd_addr |

## Verification
Some internal faults show up at the ports. A stuck or off-by-one byte counter either moves a commit or blocks it. The result is that `wip` does not rise in the cycle after chip select rises. A broken page pointer puts bytes at the wrong offsets, and `rd_data` shows this as soon as `wip` falls. A busy counter that runs wrong changes the `wip` width away from TWC cycles.

A failed acceptance check can show up in two ways. A busy period may start when it should not. Or `wel` may stay high after a rejected frame. Both are visible within one cycle of the chip-select rise.

// File: rtl/eewr_pkg.sv
// Package: shared state type, opcode fields and the protection decode.
// Assumes an address of at most 9 bits, whose top two bits select a quarter.
package eewr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_DROP
    } cmd_state_t;

    localparam logic [3:0] OPC_HIGH = 4'b0000;
    localparam logic [2:0] OPC_LOW  = 3'b010;

    // Returns 1 when the quarter given by top2 lies in the protected region.
    function automatic logic prot_hit(input logic [1:0] bp, input logic [1:0] top2);
        logic hit;
        case (bp)
            2'b00:   hit = 1'b0;
            2'b01:   hit = (top2 == 2'b11);
            2'b10:   hit = top2[1];
            default: hit = 1'b1;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/eewr_spi_rx.sv
// SPI receiver: samples the pins with the system clock, finds the edges,
// and shifts in bytes MSB first on serial-clock rises.
// Assumes the SPI pins are already synchronous to clk and that each SPI
// level lasts at least two clk cycles.
module eewr_spi_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       cs_rise,
    output logic       at_boundary
);
    logic       sclk_q;
    logic       cs_q;
    logic [6:0] shreg;
    logic [2:0] bcnt;
    logic       sclk_rise;

    assign sclk_rise   = sclk & ~sclk_q;
    assign cs_rise     = cs_n & ~cs_q;
    assign at_boundary = (bcnt == 3'd0);

    // Keep the previous pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    // Shift the bits in and count them; the count clears while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            bcnt  <= '0;
        end else if (cs_n) begin
            bcnt  <= '0;
        end else if (sclk_rise) begin
            shreg <= {shreg[5:0], mosi};
            bcnt  <= bcnt + 3'd1;
        end
    end

    // Give out a byte one cycle after its eighth bit is sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else begin
            byte_valid <= !cs_n && sclk_rise && (bcnt == 3'd7);
            if (!cs_n && sclk_rise && (bcnt == 3'd7))
                byte_data <= {shreg, mosi};
        end
    end

endmodule

// File: rtl/eewr_cmd_ctrl.sv
// Command sequencer: decodes the opcode, checks whether the write may go
// ahead once the address is known, fills the page buffer with wrapping
// offsets, and raises commit or reject when chip select rises.
// Assumes ADDR_W <= 9 and a power-of-two PAGE.
module eewr_cmd_ctrl
    import eewr_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAGE   = 16,
    localparam int OFF_W = $clog2(PAGE),
    localparam int PG_W  = ADDR_W - OFF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  byte_valid,
    input  logic [7:0]            byte_data,
    input  logic                  cs_rise,
    input  logic                  at_boundary,
    input  logic                  wel,
    input  logic                  wip,
    input  logic                  wp_n,
    input  logic [1:0]            bp,
    output logic                  commit,
    output logic                  reject,
    output logic [PG_W-1:0]       page_q,
    output logic [PAGE-1:0][7:0]  pg_data,
    output logic [PAGE-1:0]       pg_mask
);
    cmd_state_t         state;
    logic               is_wr;
    logic               a8;
    logic               have_data;
    logic [OFF_W-1:0]   ptr;
    logic [8:0]         full_addr;
    logic [ADDR_W-1:0]  addr;
    logic               guard;
    logic               accept;

    assign full_addr = {a8, byte_data};
    assign addr      = full_addr[ADDR_W-1:0];
    assign guard     = wel && !wip && wp_n;
    assign accept    = guard && !prot_hit(bp, addr[ADDR_W-1 -: 2]);
    assign commit    = cs_rise && (state == ST_DATA) && at_boundary && have_data && guard;
    assign reject    = cs_rise && is_wr && !commit;

    // Frame sequencing: opcode, then address, then data, or drop the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            is_wr     <= 1'b0;
            a8        <= 1'b0;
            have_data <= 1'b0;
        end else if (cs_n) begin
            state     <= ST_IDLE;
            is_wr     <= 1'b0;
        end else if (state == ST_IDLE) begin
            state     <= ST_OPC;
            have_data <= 1'b0;
        end else if (byte_valid) begin
            case (state)
                ST_OPC: begin
                    if (byte_data[7:4] == OPC_HIGH && byte_data[2:0] == OPC_LOW) begin
                        is_wr <= 1'b1;
                        a8    <= byte_data[3];
                        state <= ST_ADDR;
                    end else begin
                        state <= ST_DROP;
                    end
                end
                ST_ADDR: state     <= accept ? ST_DATA : ST_DROP;
                ST_DATA: have_data <= 1'b1;
                default: state     <= state;
            endcase
        end
    end

    // Page buffer: an accepted address clears it, each data byte fills one slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q  <= '0;
            ptr     <= '0;
            pg_data <= '0;
            pg_mask <= '0;
        end else if (!cs_n && byte_valid) begin
            if (state == ST_ADDR && accept) begin
                page_q  <= addr[ADDR_W-1:OFF_W];
                ptr     <= addr[OFF_W-1:0];
                pg_mask <= '0;
            end else if (state == ST_DATA) begin
                pg_data[ptr] <= byte_data;
                pg_mask[ptr] <= 1'b1;
                ptr          <= ptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/eewr_wr_engine.sv
// Write engine: times the busy period, copies the marked buffer slots into
// the array when it ends, and holds the latch and protect bits.
// Assumes the buffer stays unchanged while busy (the sequencer rejects
// every frame then).
module eewr_wr_engine #(
    parameter int ADDR_W = 9,
    parameter int PAGE   = 16,
    parameter int TWC    = 400,
    localparam int OFF_W = $clog2(PAGE),
    localparam int PG_W  = ADDR_W - OFF_W,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int CNT_W = $clog2(TWC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit,
    input  logic                 reject,
    input  logic                 preset_valid,
    input  logic                 preset_wel,
    input  logic [1:0]           preset_bp,
    input  logic [PG_W-1:0]      page_q,
    input  logic [PAGE-1:0][7:0] pg_data,
    input  logic [PAGE-1:0]      pg_mask,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic                 wel,
    output logic                 wip,
    output logic [1:0]           bp,
    output logic [7:0]           rd_data
);
    logic [7:0]       mem [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic             done;

    assign done    = wip && (cnt == CNT_W'(TWC - 1));
    assign rd_data = mem[rd_addr];

    // Busy timer: starts on commit and ends after TWC cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wip <= 1'b0;
            cnt <= '0;
        end else if (commit) begin
            wip <= 1'b1;
            cnt <= '0;
        end else if (done) begin
            wip <= 1'b0;
        end else if (wip) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Latch and protect bits: a preset wins, otherwise end or reject clears wel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel <= 1'b0;
            bp  <= 2'b00;
        end else if (preset_valid) begin
            wel <= preset_wel;
            bp  <= preset_bp;
        end else if (done || reject) begin
            wel <= 1'b0;
        end
    end

    // Array update: marked slots of the buffered page land when busy ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (done) begin
            for (int j = 0; j < PAGE; j++)
                if (pg_mask[j]) mem[{page_q, OFF_W'(j)}] <= pg_data[j];
        end
    end

endmodule

// File: rtl/eeprom_page_writer.sv
// Top: SPI page-write controller for a small serial EEPROM.
// Joins the receiver, the sequencer and the write engine. The data output
// is never driven during a write frame.
module eeprom_page_writer #(
    parameter int ADDR_W = 9,
    parameter int PAGE   = 16,
    parameter int TWC    = 400,
    localparam int OFF_W = $clog2(PAGE),
    localparam int PG_W  = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic              wp_n,
    input  logic              preset_valid,
    input  logic              preset_wel,
    input  logic [1:0]        preset_bp,
    output logic              wel,
    output logic              wip,
    output logic [1:0]        bp,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    logic                 byte_valid;
    logic [7:0]           byte_data;
    logic                 cs_rise;
    logic                 at_boundary;
    logic                 commit;
    logic                 reject;
    logic [PG_W-1:0]      page_q;
    logic [PAGE-1:0][7:0] pg_data;
    logic [PAGE-1:0]      pg_mask;

    assign spi_miso    = 1'b0;
    assign spi_miso_oe = 1'b0;

    eewr_spi_rx rx_i (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .cs_rise(cs_rise), .at_boundary(at_boundary)
    );

    eewr_cmd_ctrl #(.ADDR_W(ADDR_W), .PAGE(PAGE)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .cs_rise(cs_rise), .at_boundary(at_boundary),
        .wel(wel), .wip(wip), .wp_n(wp_n), .bp(bp),
        .commit(commit), .reject(reject),
        .page_q(page_q), .pg_data(pg_data), .pg_mask(pg_mask)
    );

    eewr_wr_engine #(.ADDR_W(ADDR_W), .PAGE(PAGE), .TWC(TWC)) eng_i (
        .clk(clk), .rst_n(rst_n), .commit(commit), .reject(reject),
        .preset_valid(preset_valid), .preset_wel(preset_wel), .preset_bp(preset_bp),
        .page_q(page_q), .pg_data(pg_data), .pg_mask(pg_mask),
        .rd_addr(rd_addr), .wel(wel), .wip(wip), .bp(bp), .rd_data(rd_data)
    );

endmodule

// File: rtl/eeprom_page_writer_chk.sv
// Checker: port-level timing rules of the page-write controller.
// It is bound to every instance of the top module.
module eeprom_page_writer_chk #(
    parameter int ADDR_W = 9,
    parameter int TWC    = 400
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              wp_n,
    input logic              preset_valid,
    input logic              wel,
    input logic              wip,
    input logic [1:0]        bp,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data
);
    logic [31:0] run_len;

    // Count the cycles wip has been high, for the busy-width check.
    always_ff @(posedge clk) begin
        if (!rst_n || !wip) run_len <= '0;
        else                run_len <= run_len + 32'd1;
    end

    AST_START_AFTER_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> ($past(spi_cs_n) && !$past(spi_cs_n, 2))); // R3
    AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wel)); // R7
    AST_START_NEEDS_WP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wp_n)); // R9
    AST_BUSY_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> (run_len == TWC)); // R6
    AST_ARRAY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && $past(wip) && $stable(rd_addr)) |-> $stable(rd_data)); // R6
    AST_WEL_CLEARED_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wip) && !$past(preset_valid)) |-> !wel); // R12
    AST_BP_ONLY_BY_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(preset_valid) |-> $stable(bp)); // R13

endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(.ADDR_W(ADDR_W), .TWC(TWC)) chk_i (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .wp_n(wp_n),
    .preset_valid(preset_valid), .wel(wel), .wip(wip), .bp(bp),
    .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/eeprom_page_writer_tb_top.sv
// Scoreboard bench: the driver tasks queue the expected array bytes, and the
// monitor task pops each one and compares it with the read port.
module eeprom_page_writer_tb_top;
    localparam int ADDR_W = 9;
    localparam int PAGE   = 16;
    localparam int TWC    = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe;
    logic wp_n = 1'b1;
    logic preset_valid = 1'b0, preset_wel = 1'b0;
    logic [1:0] preset_bp = 2'b00;
    logic wel, wip;
    logic [1:0] bp;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0] rd_data;

    int n_vec = 0;
    int n_bad = 0;
    int oe_seen = 0;

    typedef struct {
        string      req;
        int         addr;
        logic [7:0] val;
    } exp_t;
    exp_t sbq[$];

    always #5 clk = ~clk;

    eeprom_page_writer #(.ADDR_W(ADDR_W), .PAGE(PAGE), .TWC(TWC)) dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .wp_n(wp_n), .preset_valid(preset_valid), .preset_wel(preset_wel),
        .preset_bp(preset_bp), .wel(wel), .wip(wip), .bp(bp),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // R11: watch the output enable on every cycle.
    always @(negedge clk) if (spi_miso_oe !== 1'b0) oe_seen++;

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_mem(input string req, input int addr, input logic [7:0] val);
        exp_t e;
        e.req = req; e.addr = addr; e.val = val;
        sbq.push_back(e);
    endtask

    task automatic monitor_drain();
        while (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            @(negedge clk);
            rd_addr = e.addr[ADDR_W-1:0];
            #1;
            chk(e.req, int'(rd_data), int'(e.val));
        end
    endtask

    task automatic preset(input logic w, input logic [1:0] b);
        @(negedge clk);
        preset_valid = 1'b1; preset_wel = w; preset_bp = b;
        @(negedge clk);
        preset_valid = 1'b0;
    endtask

    task automatic spi_bits(input logic [7:0] v, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            @(negedge clk);
            spi_sclk = 1'b0; spi_mosi = v[i];
            repeat (3) @(negedge clk);
            spi_sclk = 1'b1;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic spi_begin();
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic spi_end();
        @(negedge clk);
        spi_sclk = 1'b0;
        repeat (3) @(negedge clk);
        spi_cs_n = 1'b1;
    endtask

    // Send the opcode, the address and n data bytes, then tail_bits of one more byte.
    task automatic wr_frame(input logic [7:0] opc, input logic [7:0] a,
                            input logic [7:0] d [], input int tail_bits);
        spi_begin();
        spi_bits(opc, 8);
        spi_bits(a, 8);
        foreach (d[k]) spi_bits(d[k], 8);
        if (tail_bits > 0) spi_bits(8'hFF, tail_bits);
        spi_end();
    endtask

    // Count the cycles with wip high, starting at the chip-select rise.
    task automatic busy_len(output int n);
        n = 0;
        repeat (TWC + 20) begin
            @(negedge clk);
            if (wip) n++;
        end
    endtask

    function automatic logic [7:0] opw(input logic a8);
        return {4'b0000, a8, 3'b010};
    endfunction

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int n;
        logic [7:0] d1 [];
        logic [7:0] d2 [];
        logic [7:0] d4 [];
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: state after reset
        chk("R1 wel", int'(wel), 0);
        chk("R1 wip", int'(wip), 0);
        chk("R1 bp", int'(bp), 0);
        chk("R1 oe", int'(spi_miso_oe), 0);
        expect_mem("R1 mem", 9'h005, 8'h00);
        monitor_drain();

        // R7: no latch set, so the frame is ignored
        d1 = new[1]; d1[0] = 8'hAA;
        wr_frame(opw(1'b0), 8'h05, d1, 0);
        busy_len(n);
        chk("R7 busy", n, 0);
        expect_mem("R7 mem", 9'h005, 8'h00);
        monitor_drain();

        // R4 R6 R12: two bytes at consecutive addresses, exact busy width
        preset(1'b1, 2'b00);
        d2 = new[2]; d2[0] = 8'hAA; d2[1] = 8'hBB;
        wr_frame(opw(1'b0), 8'h05, d2, 0);
        busy_len(n);
        chk("R6 busy width", n, TWC);
        chk("R12 wel after end", int'(wel), 0);
        expect_mem("R4 first", 9'h005, 8'hAA);
        expect_mem("R4 second", 9'h006, 8'hBB);
        expect_mem("R4 next untouched", 9'h007, 8'h00);
        monitor_drain();

        // R2: address bit 8 taken from opcode bit 3
        preset(1'b1, 2'b00);
        d1[0] = 8'hC3;
        wr_frame(opw(1'b1), 8'h10, d1, 0);
        busy_len(n);
        chk("R2 busy", n, TWC);
        expect_mem("R2 high half", 9'h110, 8'hC3);
        expect_mem("R2 low half", 9'h010, 8'h00);
        monitor_drain();

        // R5: wrap within page 1 (0x10..0x1F)
        preset(1'b1, 2'b00);
        d4 = new[4]; d4[0] = 8'h11; d4[1] = 8'h22; d4[2] = 8'h33; d4[3] = 8'h44;
        wr_frame(opw(1'b0), 8'h1E, d4, 0);
        busy_len(n);
        expect_mem("R5 0x1E", 9'h01E, 8'h11);
        expect_mem("R5 0x1F", 9'h01F, 8'h22);
        expect_mem("R5 wrap 0x10", 9'h010, 8'h33);
        expect_mem("R5 wrap 0x11", 9'h011, 8'h44);
        expect_mem("R5 next page", 9'h020, 8'h00);
        monitor_drain();

        // R3: chip select rises mid-byte
        preset(1'b1, 2'b00);
        d1[0] = 8'h55;
        wr_frame(opw(1'b0), 8'h40, d1, 4);
        busy_len(n);
        chk("R3 mid-byte busy", n, 0);
        chk("R12 wel after reject", int'(wel), 0);
        expect_mem("R3 mid-byte mem", 9'h040, 8'h00);
        monitor_drain();

        // R3: chip select rises right after the address byte
        preset(1'b1, 2'b00);
        d1 = new[0];
        wr_frame(opw(1'b0), 8'h41, d1, 0);
        busy_len(n);
        chk("R3 no data busy", n, 0);

        // R9: write protect pin low
        preset(1'b1, 2'b00);
        wp_n = 1'b0;
        d1 = new[1]; d1[0] = 8'h66;
        wr_frame(opw(1'b0), 8'h50, d1, 0);
        busy_len(n);
        wp_n = 1'b1;
        chk("R9 busy", n, 0);
        expect_mem("R9 mem", 9'h050, 8'h00);
        monitor_drain();

        // R10 R13: top quarter protected, lower address still writable
        preset(1'b1, 2'b01);
        chk("R13 bp loaded", int'(bp), 1);
        wr_frame(opw(1'b1), 8'h90, d1, 0);
        busy_len(n);
        chk("R10 bp01 top quarter", n, 0);
        preset(1'b1, 2'b01);
        d1[0] = 8'h5A;
        wr_frame(opw(1'b1), 8'h70, d1, 0);
        busy_len(n);
        chk("R10 bp01 below", n, TWC);
        expect_mem("R10 0x190", 9'h190, 8'h00);
        expect_mem("R10 0x170", 9'h170, 8'h5A);
        monitor_drain();
        preset(1'b1, 2'b10);
        wr_frame(opw(1'b1), 8'h00, d1, 0);
        busy_len(n);
        chk("R10 bp10 top half", n, 0);
        preset(1'b1, 2'b11);
        wr_frame(opw(1'b0), 8'h00, d1, 0);
        busy_len(n);
        chk("R10 bp11 all", n, 0);
        expect_mem("R10 0x100", 9'h100, 8'h00);
        expect_mem("R10 0x000", 9'h000, 8'h00);
        monitor_drain();

        // R12: another opcode leaves the latch alone
        preset(1'b1, 2'b00);
        wr_frame(8'h03, 8'h00, d1, 0);
        busy_len(n);
        chk("R12 other opcode wel", int'(wel), 1);
        chk("R12 other opcode busy", n, 0);

        // R8 R6: a frame sent while busy is ignored; the array stays frozen until the end
        d1[0] = 8'hE1;
        wr_frame(opw(1'b0), 8'hA0, d1, 0);
        @(negedge clk);
        rd_addr = 9'h0A0;
        #1;
        chk("R6 frozen while busy", int'(rd_data), 0);
        preset(1'b1, 2'b00);
        d1[0] = 8'h77;
        wr_frame(opw(1'b0), 8'hB0, d1, 0);
        @(negedge clk);
        chk("R8 still busy", int'(wip), 1);
        chk("R12 wel after busy reject", int'(wel), 0);
        busy_len(n);
        chk("R8 busy ended", int'(wip), 0);
        expect_mem("R8 first write", 9'h0A0, 8'hE1);
        expect_mem("R8 ignored write", 9'h0B0, 8'h00);
        monitor_drain();

        chk("R11 oe never set", oe_seen, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule